// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block places the signals of a microcontroller's on-chip digital peripherals onto a bank of 29 general-purpose pins. The peripherals are visited in a fixed priority order. Each enabled peripheral takes the next free pins in ascending pin order. A pin is free when it is neither reserved by its skip bit nor configured as analog. A pin that no peripheral claims carries the value of its general-purpose port latch. A peripheral signal that finds no free pin is left unrouted and raises a shortage flag.

The block also drives the output cell of each pin. Each pin is set to push-pull or open-drain. Analog pins are isolated from the digital logic. A weak pull-up works on every digital pin unless it is switched off by one global control. In the other direction, the pad inputs are routed back to the peripheral signals that own them. The per-pin digital read values are also presented. The allocation is computed combinationally from the present configuration, and every output is registered once.

Top module: `pin_crossbar`

## Requirements
- R1: There are 16 signal slots, ordered by priority: UART transmit 0 and receive 1; SPI clock 2, master-in 3, master-out 4 and select 5; SMBus data 6 and clock 7; comparator A 8; comparator B 9; system clock 10; counter-array channels 11, 12 and 13; timer 0 at 14; timer 1 at 15. The n-th enabled slot, counted in slot order, is placed on the n-th free pin, counted upward from pin 0.
- R2: Bit i of `periph_en` enables one peripheral: bit 0 UART, bit 1 SPI, bit 2 SMBus, bit 3 comparator A, bit 4 comparator B, bit 5 system clock, bit 6 counter array, bit 7 timer 0, bit 8 timer 1. The slots of a disabled peripheral take no pin, and they do not use up a free pin.
- R3: A pin whose `pin_skip` bit is 1 is never given to a peripheral. It behaves as a general-purpose pin.
- R4: A pin whose `pin_analog` bit is 1 is never given to a peripheral. It has `pad_oe`=0, `pad_do`=0 and `pad_pu`=0, and its `gpio_rd` bit reads 1.
- R5: A digital pin with no peripheral takes its source value from `gpio_latch` and has a source enable of 1.
- R6: In push-pull mode (`pin_pushpull`=1), `pad_oe` equals the source enable and `pad_do` equals the source value.
- R7: In open-drain mode (`pin_pushpull`=0), `pad_do` is 0. `pad_oe` is 1 only when the source enable is 1 and the source value is 0.
- R8: `pad_pu` is 1 only when `pullup_off` is 0, the pin is digital, and the pin is not actively driving low (`pad_oe`=1 with `pad_do`=0).
- R9: `slot_in` of a routed slot follows the pad input of its pin. `slot_in` of an unrouted slot reads 1.
- R10: `no_pin` is 1 exactly when the enabled slots outnumber the free pins. The slots that do not fit are unrouted.
- R11: Every output shows the inputs that were present at the previous rising clock edge. While `rst_n` is low the outputs are held at these values: `pad_oe`, `pad_do` and `pad_pu` all 0; `slot_in` and `gpio_rd` all 1; `no_pin` 0.
- R12: `gpio_rd` of a digital pin follows its `pad_in` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_en | input | 9 | Enable bit for each peripheral |
| pin_skip | input | 29 | 1 reserves the pin from assignment |
| pin_analog | input | 29 | 1 puts the pin in analog mode |
| pin_pushpull | input | 29 | 1 selects push-pull, 0 selects open-drain |
| pullup_off | input | 1 | Global weak pull-up disable |
| gpio_latch | input | 29 | General-purpose output value of each pin |
| slot_out | input | 16 | Peripheral output value for each slot |
| slot_oe | input | 16 | Peripheral output enable for each slot |
| pad_in | input | 29 | Value sensed at each pad |
| pad_do | output | 29 | Drive value for each pad |
| pad_oe | output | 29 | Drive enable for each pad |
| pad_pu | output | 29 | Weak pull-up enable for each pad |
| gpio_rd | output | 29 | Digital read value of each pin |
| slot_in | output | 16 | Pad input routed back to each slot |
| no_pin | output | 1 | Some enabled slot found no free pin |

## Verification
The assertions compare each registered output with the inputs that were sampled one edge earlier. They therefore assume that every input has a known 0 or 1 value at each rising edge, and that no input changes close to that edge. The bench sets every input to a defined value before reset is released. After that it changes inputs only on falling edges, and it reads outputs one full falling edge later, so each sampled output comes from exactly one set of inputs.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    localparam int NUM_PERIPH   = 9;
    localparam int PCA_CHANNELS = 3;

    // Signals carried by each peripheral, listed in priority order.
    function automatic int periph_width(input int idx);
        case (idx)
            0:       return 2;             // UART
            1:       return 4;             // SPI
            2:       return 2;             // SMBus
            6:       return PCA_CHANNELS;  // counter array
            default: return 1;             // comparators, sysclk, timers
        endcase
    endfunction

    function automatic int total_slots();
        int sum;
        sum = 0;
        for (int i = 0; i < NUM_PERIPH; i++) sum += periph_width(i);
        return sum;
    endfunction

    localparam int NUM_SLOTS = total_slots();

    // Peripheral that owns a given slot.
    function automatic int slot_owner(input int slot);
        int base;
        base = 0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (slot < base + periph_width(i)) return i;
            base += periph_width(i);
        end
        return NUM_PERIPH - 1;
    endfunction

endpackage

// File: rtl/pxb_alloc.sv
module pxb_alloc #(
    parameter int NUM_PINS  = 29,
    parameter int NUM_SLOTS = 16
) (
    input  logic [NUM_PINS-1:0]  free_pin,
    input  logic [NUM_SLOTS-1:0] slot_req,
    output logic [NUM_PINS-1:0]  pin_taken,
    output logic [((NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1)-1:0] pin_src [NUM_PINS],
    output logic [NUM_SLOTS-1:0] slot_taken,
    output logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0]   slot_dst [NUM_SLOTS],
    output logic                 short_of_pins
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int MAXN   = (NUM_PINS > NUM_SLOTS) ? NUM_PINS : NUM_SLOTS;
    localparam int RW     = $clog2(MAXN + 1);

    logic [RW-1:0] pin_rank  [NUM_PINS];
    logic [RW-1:0] slot_rank [NUM_SLOTS];
    logic [RW-1:0] free_cnt, req_cnt;

    // Rank of each free pin and of each requesting slot: the n-th requester
    // meets the n-th free pin, which matches a priority walk in ascending order.
    always_comb begin
        free_cnt = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            pin_rank[p] = free_cnt;
            free_cnt    = free_cnt + RW'(free_pin[p]);
        end
        req_cnt = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            slot_rank[s] = req_cnt;
            req_cnt      = req_cnt + RW'(slot_req[s]);
        end

        pin_taken  = '0;
        slot_taken = '0;
        for (int p = 0; p < NUM_PINS; p++) pin_src[p] = '0;
        for (int s = 0; s < NUM_SLOTS; s++) slot_dst[s] = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (free_pin[p] && slot_req[s] && (pin_rank[p] == slot_rank[s])) begin
                    pin_taken[p]  = 1'b1;
                    pin_src[p]    = SLOT_W'(s);
                    slot_taken[s] = 1'b1;
                    slot_dst[s]   = PIN_W'(p);
                end
            end
        end
        short_of_pins = (req_cnt > free_cnt);
    end

endmodule

// File: rtl/pxb_pad_cell.sv
module pxb_pad_cell (
    input  logic analog,
    input  logic push_pull,
    input  logic pu_disable,
    input  logic src_val,
    input  logic src_oe,
    input  logic pad_raw,
    output logic drv_val,
    output logic drv_oe,
    output logic pu_en,
    output logic dig_rd
);
    always_comb begin
        if (analog) begin
            drv_oe  = 1'b0;
            drv_val = 1'b0;
        end else if (push_pull) begin
            drv_oe  = src_oe;
            drv_val = src_val;
        end else begin
            drv_oe  = src_oe & ~src_val;   // a 1 releases the line
            drv_val = 1'b0;
        end
        pu_en  = ~pu_disable & ~analog & ~(drv_oe & ~drv_val);
        dig_rd = analog | pad_raw;
    end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
    import pxb_pkg::*;
#(
    parameter int NUM_PINS = 29
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] periph_en,
    input  logic [NUM_PINS-1:0]   pin_skip,
    input  logic [NUM_PINS-1:0]   pin_analog,
    input  logic [NUM_PINS-1:0]   pin_pushpull,
    input  logic                  pullup_off,
    input  logic [NUM_PINS-1:0]   gpio_latch,
    input  logic [NUM_SLOTS-1:0]  slot_out,
    input  logic [NUM_SLOTS-1:0]  slot_oe,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_do,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_pu,
    output logic [NUM_PINS-1:0]   gpio_rd,
    output logic [NUM_SLOTS-1:0]  slot_in,
    output logic                  no_pin
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    typedef struct packed {
        logic [NUM_PINS-1:0]  pdo;
        logic [NUM_PINS-1:0]  poe;
        logic [NUM_PINS-1:0]  ppu;
        logic [NUM_PINS-1:0]  prd;
        logic [NUM_SLOTS-1:0] sin;
        logic                 short;
    } xbar_state_t;

    xbar_state_t st_d, st_q;

    logic [NUM_PINS-1:0]  free_pin;
    logic [NUM_SLOTS-1:0] slot_req;
    logic [NUM_PINS-1:0]  pin_taken;
    logic [SLOT_W-1:0]    pin_src [NUM_PINS];
    logic [NUM_SLOTS-1:0] slot_taken;
    logic [PIN_W-1:0]     slot_dst [NUM_SLOTS];
    logic                 short_of_pins;
    logic [NUM_PINS-1:0]  src_val, src_oe;
    logic [NUM_PINS-1:0]  cell_val, cell_oe, cell_pu, cell_rd;

    assign free_pin = ~pin_skip & ~pin_analog;

    // Each slot inherits the enable of the peripheral that owns it.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_req
        localparam int OWNER = slot_owner(s);
        assign slot_req[s] = periph_en[OWNER];
    end

    pxb_alloc #(
        .NUM_PINS  (NUM_PINS),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_alloc (
        .free_pin      (free_pin),
        .slot_req      (slot_req),
        .pin_taken     (pin_taken),
        .pin_src       (pin_src),
        .slot_taken    (slot_taken),
        .slot_dst      (slot_dst),
        .short_of_pins (short_of_pins)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign src_val[p] = pin_taken[p] ? slot_out[pin_src[p]] : gpio_latch[p];
        assign src_oe[p]  = pin_taken[p] ? slot_oe[pin_src[p]]  : 1'b1;

        pxb_pad_cell u_cell (
            .analog     (pin_analog[p]),
            .push_pull  (pin_pushpull[p]),
            .pu_disable (pullup_off),
            .src_val    (src_val[p]),
            .src_oe     (src_oe[p]),
            .pad_raw    (pad_in[p]),
            .drv_val    (cell_val[p]),
            .drv_oe     (cell_oe[p]),
            .pu_en      (cell_pu[p]),
            .dig_rd     (cell_rd[p])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.pdo   = cell_val;
        st_d.poe   = cell_oe;
        st_d.ppu   = cell_pu;
        st_d.prd   = cell_rd;
        st_d.short = short_of_pins;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            st_d.sin[s] = slot_taken[s] ? cell_rd[slot_dst[s]] : 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pdo   <= '0;
            st_q.poe   <= '0;
            st_q.ppu   <= '0;
            st_q.prd   <= '1;
            st_q.sin   <= '1;
            st_q.short <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pad_do  = st_q.pdo;
    assign pad_oe  = st_q.poe;
    assign pad_pu  = st_q.ppu;
    assign gpio_rd = st_q.prd;
    assign slot_in = st_q.sin;
    assign no_pin  = st_q.short;

    // R4: an analog pin is undriven, unpulled and reads 1
    a_r4_analog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_pu | ~gpio_rd) & $past(pin_analog)) == '0);

    // R7: an open-drain pin never drives a 1
    a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_do & ~$past(pin_pushpull)) == '0);

    // R8: the global disable removes every pull-up
    a_r8_pullup_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pullup_off) |-> (pad_pu == '0));

    // R3: a skipped digital push-pull pin shows its port latch
    a_r3_skip_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_do ^ $past(gpio_latch)) & $past(pin_skip & ~pin_analog & pin_pushpull)) == '0);

    // R10: a shortage needs at least one enabled peripheral
    a_r10_short_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        no_pin |-> ($past(periph_en) != '0));

endmodule

// File: tb/sim_pin_crossbar.sv
module sim_pin_crossbar;

    localparam logic [28:0] ONES = 29'h1FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  periph_en = '0;
    logic [28:0] pin_skip = '0, pin_analog = '0, pin_pushpull = ONES;
    logic        pullup_off = 1'b0;
    logic [28:0] gpio_latch = '0, pad_in = ONES;
    logic [15:0] slot_out = '0, slot_oe = '1;
    logic [28:0] pad_do, pad_oe, pad_pu, gpio_rd;
    logic [15:0] slot_in;
    logic        no_pin;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pin_crossbar u0 (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .pin_skip(pin_skip),
        .pin_analog(pin_analog), .pin_pushpull(pin_pushpull), .pullup_off(pullup_off),
        .gpio_latch(gpio_latch), .slot_out(slot_out), .slot_oe(slot_oe), .pad_in(pad_in),
        .pad_do(pad_do), .pad_oe(pad_oe), .pad_pu(pad_pu), .gpio_rd(gpio_rd),
        .slot_in(slot_in), .no_pin(no_pin)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // enables, skip, analog, probed slot, expected pin (63 = none), expected shortage
    typedef struct packed {
        logic [8:0]  en;
        logic [28:0] skip;
        logic [28:0] ana;
        logic [4:0]  probe;
        logic [5:0]  pin;
        logic        ovf;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{9'h1FF, 29'h0,         29'h0,         5'd15, 6'd15, 1'b0},
        '{9'h001, 29'h0,         29'h0,         5'd1,  6'd1,  1'b0},
        '{9'h002, 29'h5,         29'h0,         5'd5,  6'd5,  1'b0},
        '{9'h003, 29'h0,         29'hF,         5'd2,  6'd6,  1'b0},
        '{9'h040, 29'h0,         29'h0,         5'd13, 6'd2,  1'b0},
        '{9'h1BF, 29'h0,         29'h0,         5'd12, 6'd63, 1'b0},
        '{9'h1BF, 29'h0,         29'h0,         5'd14, 6'd11, 1'b0},
        '{9'h1FF, 29'h1FFF_FF00, 29'h0,         5'd7,  6'd7,  1'b1},
        '{9'h1FF, 29'h1FFF_FF00, 29'h0,         5'd8,  6'd63, 1'b1},
        '{9'h100, 29'h0000_00FF, 29'h0000_FF00, 5'd15, 6'd16, 1'b0},
        '{9'h028, 29'h2,         29'h1,         5'd10, 6'd3,  1'b0},
        '{9'h1FF, 29'h1FFF_0000, 29'h0,         5'd15, 6'd15, 1'b0},
        '{9'h001, ONES,          29'h0,         5'd0,  6'd63, 1'b1},
        '{9'h001, 29'h0FFF_FFFF, 29'h0,         5'd0,  6'd28, 1'b1}
    };

    initial begin
        repeat (10000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R11: reset values
        repeat (3) @(negedge clk);
        check("R11 reset pad_oe", 64'(pad_oe), 64'(0));
        check("R11 reset pad_do", 64'(pad_do), 64'(0));
        check("R11 reset pad_pu", 64'(pad_pu), 64'(0));
        check("R11 reset slot_in", 64'(slot_in), 64'(16'hFFFF));
        check("R11 reset gpio_rd", 64'(gpio_rd), 64'(ONES));
        check("R11 reset no_pin", 64'(no_pin), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R5 latch low", 64'(pad_do), 64'(0));

        // R11: no change before the edge; R5 and R2 after it
        gpio_latch = ONES;
        #1;
        check("R11 held before edge", 64'(pad_do), 64'(0));
        @(negedge clk);
        check("R5 R2 latch high", 64'(pad_do), 64'(ONES));
        check("R5 source enable", 64'(pad_oe), 64'(ONES));

        // R9 unrouted slots read 1, R12 digital read
        pad_in = '0;
        @(negedge clk);
        check("R9 unrouted reads 1", 64'(slot_in), 64'(16'hFFFF));
        check("R12 digital read", 64'(gpio_rd), 64'(0));

        // R3 skipped pins act as GPIO
        periph_en = 9'h001; pin_skip = 29'h3; gpio_latch = '0;
        slot_out = 16'hFFFF; pad_in = ONES & ~29'h4;
        @(negedge clk);
        check("R3 skip", 64'(pad_do), 64'(29'hC));
        check("R9 routed input", 64'(slot_in), 64'(16'hFFFE));

        // R6 push-pull follows slot enable, R8 pull-up
        pin_skip = '0; slot_oe = 16'hFFFE;
        @(negedge clk);
        check("R6 pp oe", 64'(pad_oe), 64'(29'h1FFF_FFFE));
        check("R6 pp do", 64'(pad_do), 64'(29'h3));
        check("R8 pp pullup", 64'(pad_pu), 64'(29'h3));

        // R4 analog pin
        periph_en = '0; slot_oe = '1; pin_analog = 29'h20; gpio_latch = ONES; pad_in = '0;
        @(negedge clk);
        check("R4 analog oe", 64'(pad_oe), 64'(29'h1FFF_FFDF));
        check("R4 analog pu", 64'(pad_pu), 64'(29'h1FFF_FFDF));
        check("R4 R12 analog read", 64'(gpio_rd), 64'(29'h20));

        // R7 open-drain GPIO, R8
        pin_analog = '0; pin_pushpull = '0; gpio_latch = 29'h0AAA_AAAA;
        @(negedge clk);
        check("R7 od oe", 64'(pad_oe), 64'(29'h1555_5555));
        check("R7 od do", 64'(pad_do), 64'(0));
        check("R8 od pullup", 64'(pad_pu), 64'(29'h0AAA_AAAA));
        pullup_off = 1'b1;
        @(negedge clk);
        check("R8 global off", 64'(pad_pu), 64'(0));

        // R7 open-drain peripheral
        pullup_off = 1'b0; periph_en = 9'h001; slot_out = 16'hFFFE; gpio_latch = ONES;
        @(negedge clk);
        check("R7 od periph", 64'(pad_oe), 64'(29'h1));

        // Table: R1 R2 R3 R4 R10 placements
        pin_pushpull = ONES; gpio_latch = ONES; slot_oe = '1;
        for (int i = 0; i < NV; i++) begin
            periph_en  = VECS[i].en;
            pin_skip   = VECS[i].skip;
            pin_analog = VECS[i].ana;
            slot_out   = ~(16'h1 << VECS[i].probe);
            pad_in     = (VECS[i].pin == 6'd63) ? ONES : (ONES & ~(29'h1 << VECS[i].pin));
            @(negedge clk);
            check($sformatf("R1 vec%0d pin", i), 64'(pad_oe & ~pad_do),
                  (VECS[i].pin == 6'd63) ? 64'(0) : 64'(29'h1 << VECS[i].pin));
            check($sformatf("R9 vec%0d input", i), 64'(slot_in[VECS[i].probe]),
                  (VECS[i].pin == 6'd63) ? 64'(1) : 64'(0));
            check($sformatf("R10 vec%0d short", i), 64'(no_pin), 64'(VECS[i].ovf));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule